// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the write-only control port of a two-channel voice transcoder. Several such devices share one three-wire bus: a chip select, a serial clock and a data line. Each device has a six-bit address set by strap pins. The port collects bits into bytes. The first byte names a device and one of its two channels. The bytes that follow load that channel's coding control byte and, optionally, its input and output time slot numbers. A transaction that names another device is dropped without any side effect.

The serial inputs are sampled by the block's own clock. The bus clock must therefore be several system clocks slower than that clock. A rising edge is found by comparing each sample of the serial clock with the previous one. While a matched transaction is open, the port raises a flag that the data path uses to float both channel outputs. The algorithm-reset bit of each channel clears itself when the processing engine reports that the channel's reset is complete.

Top module: `cfgport_top`

## Requirements
- R1: After a synchronous active-low reset, both control registers read 0x20 (only the idle bit, bit 5, set) and all four time slot registers read 0. The update flag is low.
- R2: The data line is taken on rising serial clock edges, least significant bit first. Edges seen while chip select is high shift nothing and advance no bit count.
- R3: The first byte of a transaction matches only when bit 7 is 0 and bits 5..0 equal the strap address. When it matches, bit 6 picks the target: 1 for channel X, 0 for channel Y.
- R4: After a non-matching first byte, the rest of the transaction changes no register and the update flag stays low.
- R5: A two-byte transaction loads the whole target control register and leaves both of its time slot registers unchanged.
- R6: A four-byte transaction loads the control register, then the input slot from bits 5..0 of the third byte, then the output slot from bits 5..0 of the fourth byte. Bits 7..6 of both slot bytes are dropped.
- R7: A transaction that ends with a partial byte, or after only the first byte, commits nothing beyond the bytes that were already complete.
- R8: Bytes after the fourth in one transaction are ignored.
- R9: A one-cycle pulse on a channel's algorithm-done input clears bit 4 of that channel's control register. The pulse leaves that register's other bits and the other channel untouched.
- R10: The update flag rises once a matching first byte completes. It stays high until chip select returns high, and it is low again one clock after that.
- R11: A write to one channel leaves every register of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 6 | Strapped device address |
| sclk | input | 1 | Serial bus clock |
| sdi | input | 1 | Serial data, LSB first |
| cs_n | input | 1 | Chip select, active low |
| alg_done_x | input | 1 | Channel X algorithm reset finished (pulse) |
| alg_done_y | input | 1 | Channel Y algorithm reset finished (pulse) |
| ctrl_x | output | 8 | Channel X control register |
| its_x | output | 6 | Channel X input time slot |
| ots_x | output | 6 | Channel X output time slot |
| ctrl_y | output | 8 | Channel Y control register |
| its_y | output | 6 | Channel Y input time slot |
| ots_y | output | 6 | Channel Y output time slot |
| upd_busy | output | 1 | Register update in progress; floats data outputs |

## Verification
The port is exercised with four-byte, two-byte and over-long writes to each channel. These show whether byte position steers data to the right register and whether the transaction length stops it there. It is also given first bytes that differ from a match only in the address field or only in the reserved bit, and transactions cut off after the first byte or in the middle of a byte. These separate a correct match and commit rule from one that is too loose or commits too early. Serial clock pulses sent while chip select is high, followed by a write with an asymmetric control value, expose a shifter that counts while deselected or that reverses the bit order. Done pulses on one channel at a time confirm that the self-clear hits only bit 4 of the right register.

// File: rtl/cfgport_pkg.sv
// Package: constants and types shared by the configuration port.
// Assumes the bus byte is 8 bits and that there are exactly two channels.
package cfgport_pkg;
    localparam int BYTE_W       = 8;
    localparam int NCH          = 2;
    localparam int ACB_RSV_BIT  = 7;
    localparam int ACB_SEL_BIT  = 6;
    localparam int CTRL_IPD_BIT = 5;
    localparam int CTRL_ALR_BIT = 4;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h20;

    typedef enum logic [2:0] {
        POS_ACB,
        POS_CTRL,
        POS_ITS,
        POS_OTS,
        POS_DONE
    } byte_pos_t;
endpackage

// File: rtl/sp_shift.sv
// Serial shifter: finds rising sclk edges by comparing each sample with the
// previous one, and shifts sdi in LSB first while cs_n is low. It pulses
// byte_vld for one clock when the eighth bit lands. Assumes sclk is much
// slower than clk. Raising cs_n throws away any partial byte.
module sp_shift
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rise;

    // Rising edge of the sampled serial clock, only while selected.
    assign rise = sclk && !sclk_q && !cs_n;

    // Shift register, bit counter and byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            sclk_q   <= sclk;
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {sdi, shreg[BYTE_W-1:1]};
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {sdi, shreg[BYTE_W-1:1]};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_frame.sv
// Byte framer: tracks the position of each byte in the open transaction,
// checks the first byte against the strap address, latches the channel
// select bit and produces the write strobes. Assumes byte_vld comes from
// sp_shift. A high cs_n closes the transaction.
module sp_frame
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_q,
    output logic              matched,
    output logic              chan_sel,
    output logic              wr_ctrl,
    output logic              wr_its,
    output logic              wr_ots
);
    byte_pos_t pos;
    logic      hit;

    // Address match: reserved bit clear and address field equal.
    assign hit = !byte_q[ACB_RSV_BIT] && (byte_q[ADDR_W-1:0] == dev_addr);

    // Position tracker and match/select latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= POS_ACB;
            matched  <= 1'b0;
            chan_sel <= 1'b0;
        end else if (cs_n) begin
            pos     <= POS_ACB;
            matched <= 1'b0;
        end else if (byte_vld) begin
            unique case (pos)
                POS_ACB: begin
                    matched  <= hit;
                    chan_sel <= byte_q[ACB_SEL_BIT];
                    pos      <= POS_CTRL;
                end
                POS_CTRL: pos <= POS_ITS;
                POS_ITS:  pos <= POS_OTS;
                POS_OTS:  pos <= POS_DONE;
                default:  pos <= POS_DONE;
            endcase
        end
    end

    // Write strobes for the addressed register.
    always_comb begin
        wr_ctrl = byte_vld && matched && !cs_n && (pos == POS_CTRL);
        wr_its  = byte_vld && matched && !cs_n && (pos == POS_ITS);
        wr_ots  = byte_vld && matched && !cs_n && (pos == POS_OTS);
    end
endmodule

// File: rtl/sp_chanregs.sv
// Register set of one channel: the control byte plus the input and output
// time slots. The algorithm-reset bit clears itself when alg_done pulses.
// A write in the same cycle takes priority over the self-clear.
module sp_chanregs
    import cfgport_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_its,
    input  logic              wr_ots,
    input  logic [BYTE_W-1:0] din,
    input  logic              alg_done,
    output logic [BYTE_W-1:0] ctrl,
    output logic [SLOT_W-1:0] its,
    output logic [SLOT_W-1:0] ots
);
    // Control register with self-clearing algorithm-reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl <= din;
        end else if (alg_done) begin
            ctrl[CTRL_ALR_BIT] <= 1'b0;
        end
    end

    // Time slot registers; reserved upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            its <= '0;
            ots <= '0;
        end else begin
            if (wr_its) its <= din[SLOT_W-1:0];
            if (wr_ots) ots <= din[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/cfgport_top.sv
// Addressed serial configuration port for a two-channel transcoder.
// It chains the shifter and the framer, and one register set per channel.
// Channel index 1 is X and index 0 is Y, the same value as the select bit.
// upd_busy is high while a matched transaction is open.
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              alg_done_x,
    input  logic              alg_done_y,
    output logic [7:0]        ctrl_x,
    output logic [SLOT_W-1:0] its_x,
    output logic [SLOT_W-1:0] ots_x,
    output logic [7:0]        ctrl_y,
    output logic [SLOT_W-1:0] its_y,
    output logic [SLOT_W-1:0] ots_y,
    output logic              upd_busy
);
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;
    logic              matched, chan_sel, wr_ctrl, wr_its, wr_ots;
    logic [NCH-1:0]    done_v;
    logic [BYTE_W-1:0] ctrl_a [NCH];
    logic [SLOT_W-1:0] its_a  [NCH];
    logic [SLOT_W-1:0] ots_a  [NCH];

    sp_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .byte_vld(byte_vld), .byte_q(byte_q)
    );

    sp_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dev_addr(dev_addr),
        .byte_vld(byte_vld), .byte_q(byte_q), .matched(matched),
        .chan_sel(chan_sel), .wr_ctrl(wr_ctrl), .wr_its(wr_its), .wr_ots(wr_ots)
    );

    assign done_v = {alg_done_x, alg_done_y};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = (chan_sel == 1'(g));
        sp_chanregs #(.SLOT_W(SLOT_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_ctrl(wr_ctrl && sel), .wr_its(wr_its && sel), .wr_ots(wr_ots && sel),
            .din(byte_q), .alg_done(done_v[g]),
            .ctrl(ctrl_a[g]), .its(its_a[g]), .ots(ots_a[g])
        );
    end

    assign ctrl_x   = ctrl_a[1];
    assign its_x    = its_a[1];
    assign ots_x    = ots_a[1];
    assign ctrl_y   = ctrl_a[0];
    assign its_y    = its_a[0];
    assign ots_y    = ots_a[0];
    assign upd_busy = matched;
endmodule

// File: rtl/cfgport_checker.sv
// Property checker for cfgport_top, attached with bind. It watches only
// the top-level ports.
module cfgport_checker #(
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              alg_done_x,
    input logic              alg_done_y,
    input logic [7:0]        ctrl_x,
    input logic [SLOT_W-1:0] its_x,
    input logic [SLOT_W-1:0] ots_x,
    input logic [7:0]        ctrl_y,
    input logic [SLOT_W-1:0] its_y,
    input logic [SLOT_W-1:0] ots_y,
    input logic              upd_busy
);
    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctrl_x == 8'h20 && ctrl_y == 8'h20 && its_x == '0 &&
                           ots_x == '0 && its_y == '0 && ots_y == '0 && !upd_busy));

    assert_busy_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !upd_busy);

    assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_busy |=> $stable({ctrl_x[7:5], ctrl_x[3:0], ctrl_y[7:5], ctrl_y[3:0],
                               its_x, ots_x, its_y, ots_y}));

    assert_selfclear_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_done_x && !upd_busy) |=> !ctrl_x[4]);

    assert_selfclear_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_done_y && !upd_busy) |=> !ctrl_y[4]);
endmodule

bind cfgport_top cfgport_checker #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/cfgport_top_test.sv
// Scoreboard bench: the driver runs bus transactions and pushes the
// expected register image; the monitor pops it and compares it with the ports.
module cfgport_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] dev_addr = 6'h2A;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic alg_done_x = 1'b0, alg_done_y = 1'b0;
    logic [7:0] ctrl_x, ctrl_y;
    logic [5:0] its_x, ots_x, its_y, ots_y;
    logic upd_busy;

    int tests = 0, fails = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];
    event        txn_done;
    logic [7:0]  mcx = 8'h20, mcy = 8'h20;
    logic [5:0]  mix = 0, mox = 0, miy = 0, moy = 0;
    logic [7:0]  tbytes [8];

    always #2.5 clk = ~clk;

    cfgport_top uut (.*);

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sdi = b[i]; sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    // Runs one transaction: nbytes whole bytes, then tail bits of the next.
    task automatic run_txn(input int nbytes, input int tail, input bit exp_busy, input string tag);
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < nbytes; k++) begin
            send_bits(tbytes[k], 8);
            if (k == 0) begin
                repeat (3) @(negedge clk);
                check({tag, " R10 busy"}, 40'(upd_busy), 40'(exp_busy));
            end
        end
        if (tail > 0) send_bits(tbytes[nbytes], tail);
        repeat (4) @(negedge clk);
        cs_n = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
        check({tag, " R10 busy off"}, 40'(upd_busy), 40'd0);
    endtask

    task automatic expect_regs(input string tag);
        repeat (4) @(negedge clk);
        exp_q.push_back({mcx, mix, mox, mcy, miy, moy});
        tag_q.push_back(tag);
        -> txn_done;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each expected image with the outputs.
    initial begin
        forever begin
            @(txn_done);
            @(negedge clk);
            while (exp_q.size() > 0)
                check(tag_q.pop_front(), {ctrl_x, its_x, ots_x, ctrl_y, its_y, ots_y},
                      exp_q.pop_front());
        end
    end

    initial begin
        repeat (1000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset busy", 40'(upd_busy), 40'd0);
        expect_regs("R1 reset values");

        // R6 R3: full write to X (select bit 1), slot upper bits dropped.
        tbytes[0] = 8'h6A; tbytes[1] = 8'h9B; tbytes[2] = 8'h45; tbytes[3] = 8'hFF;
        run_txn(4, 0, 1'b1, "R6 x4");
        mcx = 8'h9B; mix = 6'h05; mox = 6'h3F;
        expect_regs("R6 R3 four-byte X");

        // R6 R11: full write to Y leaves X.
        tbytes[0] = 8'h2A; tbytes[1] = 8'h12; tbytes[2] = 8'h0C; tbytes[3] = 8'h21;
        run_txn(4, 0, 1'b1, "R6 y4");
        mcy = 8'h12; miy = 6'h0C; moy = 6'h21;
        expect_regs("R11 four-byte Y keeps X");

        // R5: two-byte write to X keeps its slots.
        tbytes[0] = 8'h6A; tbytes[1] = 8'h9A;
        run_txn(2, 0, 1'b1, "R5 x2");
        mcx = 8'h9A;
        expect_regs("R5 two-byte X keeps slots");

        // R4: address field mismatch.
        tbytes[0] = 8'h55; tbytes[1] = 8'h00; tbytes[2] = 8'h01; tbytes[3] = 8'h02;
        run_txn(4, 0, 1'b0, "R4 mismatch");
        expect_regs("R4 mismatch ignored");

        // R3: reserved bit set with correct address.
        tbytes[0] = 8'hEA; tbytes[1] = 8'h00;
        run_txn(2, 0, 1'b0, "R3 rsv");
        expect_regs("R3 reserved bit blocks match");

        // R7: partial control byte, then address-only transaction.
        tbytes[0] = 8'h6A; tbytes[1] = 8'h00;
        run_txn(1, 5, 1'b1, "R7 partial");
        expect_regs("R7 partial byte commits nothing");
        run_txn(1, 0, 1'b1, "R7 addr only");
        expect_regs("R7 address-only commits nothing");

        // R9: done pulse on Y clears only Y bit 4; then X.
        @(negedge clk); alg_done_y = 1'b1; @(negedge clk); alg_done_y = 1'b0;
        mcy = 8'h02;
        expect_regs("R9 done Y clears Y bit4 only");
        tbytes[0] = 8'h6A; tbytes[1] = 8'h9B;
        run_txn(2, 0, 1'b1, "R9 setx");
        mcx = 8'h9B;
        @(negedge clk); alg_done_x = 1'b1; @(negedge clk); alg_done_x = 1'b0;
        mcx = 8'h8B;
        expect_regs("R9 done X clears X bit4 only");

        // R8: six-byte write to Y, extra bytes dropped.
        tbytes[0] = 8'h2A; tbytes[1] = 8'h81; tbytes[2] = 8'h07; tbytes[3] = 8'h09;
        tbytes[4] = 8'h11; tbytes[5] = 8'h22;
        run_txn(6, 0, 1'b1, "R8 y6");
        mcy = 8'h81; miy = 6'h07; moy = 6'h09;
        expect_regs("R8 bytes past fourth ignored");

        // R2: clock pulses while deselected, then an LSB-first write.
        send_bits(8'hFF, 8);
        send_bits(8'h00, 3);
        tbytes[0] = 8'h6A; tbytes[1] = 8'h01;
        run_txn(2, 0, 1'b1, "R2 x2");
        mcx = 8'h01;
        expect_regs("R2 deselected edges ignored, LSB first");

        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule